// File: doc/BRIEF.md
# Low-Power Mode and Wake-Up Controller

This block sits beside a small 8-bit microcontroller core and decides when that core gets a clock. Software writes a two-bit power-control value. Bit 1 requests deep sleep: the core clock stops and the oscillator enable drops. Bit 0 requests light sleep: only the core clock stops and the oscillator keeps running. If both bits are written together, deep sleep wins. The core clock is gated from the cycle after the accepted write, so the writing instruction is the last one the core executes.

Ten active-low pins can wake the core: a clock-style line, a data-style line and an 8-bit port. Any of them can do it, because their AND feeds an asynchronous set latch that is armed only while asleep. In deep sleep the latch raises the oscillator enable directly, since no clock is running. Its output then crosses into the clock domain through two flops. A stabilisation count of `STAB_CYC` oscillator cycles follows before the core clock returns. A hardware reset takes the same count before the core runs.

On wake the block gives the core a one-cycle wake action. The core either vectors to the wake service routine (and later returns to the next instruction) or just resumes at the next instruction. The choice depends on the interrupt-enable state captured when sleep was entered. A wake flag is set by hardware on every wake and is cleared only when the core acknowledges entry to the service routine. While asleep the block also drives override controls for the address-latch and program-strobe pins and for ports 0 and 2.

Top module: `pwr_wake_ctrl`

States: `ST_BOOT` (post-reset settle), `ST_RUN`, `ST_IDLE`, `ST_PDOWN`, `ST_STAB` (oscillator settle after a deep-sleep wake), `ST_WAKE` (one-cycle wake action). Transitions:
- BOOT→RUN when the count expires.
- RUN/WAKE→PDOWN on a write with bit 1 set.
- RUN/WAKE→IDLE on a write with only bit 0 set.
- WAKE→RUN otherwise.
- IDLE→WAKE on a synchronised wake.
- PDOWN→STAB on a synchronised wake.
- STAB→WAKE when the count expires.
- Any state→BOOT on reset.

## Requirements
- R1: After reset is released, `cpu_clk_en` stays low for exactly `STAB_CYC` rising clock edges and is high after the last of them. During reset and this settle period `osc_en` is high, `idf` is 0 and no override is active.
- R2: A `pcon_we` pulse with `pcon_wdata[1]`=1 while the core clock runs enters deep sleep. From the next cycle `cpu_clk_en`=0, `osc_en`=0, and `ale_ovr_en`/`psen_ovr_en`=1 with `ale_ovr_val`/`psen_ovr_val`=0.
- R3: A write with `pcon_wdata`=2'b01 enters light sleep. From the next cycle `cpu_clk_en`=0, `osc_en` stays 1, and both override enables and values are 1.
- R4: A write with `pcon_wdata`=2'b11 behaves exactly as deep sleep.
- R5: While asleep, a falling edge on any one of `wake_clk_n`, `wake_data_n` or `wake_p2_n[7:0]` wakes the block. In deep sleep `osc_en` rises with no clock edge needed.
- R6: Counting rising edges from the first one after the wake edge, the wake-action cycle starts on edge 3 after light sleep and on edge 3+`STAB_CYC` after deep sleep. `cpu_clk_en` is low before that cycle and high in it.
- R7: In the wake-action cycle, exactly one of `wake_vec` (interrupts enabled) or `wake_resume` (interrupts disabled) is high, for one cycle only.
- R8: The interrupt-enable choice is the value of `ie_en` in the cycle of the accepted sleep write. Changes to `ie_en` while asleep have no effect on which output pulses.
- R9: `idf` is set when the wake-action cycle begins and is cleared by `isr_ack`. When a wake and `isr_ack` meet in the same cycle, the set wins. Without `isr_ack`, `idf` stays 1.
- R10: `p0_float` = `ext_prog` in either sleep mode. `p2_hold_data` = `ext_prog` in deep sleep only, and is 0 in light sleep.
- R11: A hardware reset during deep sleep raises `osc_en` at once, clears `idf`, and leads to a full R1 settle.
- R12: Wake-pin falling edges while the core runs cause no wake action and leave `idf` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; stops while `osc_en` is low |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| pcon_we | input | 1 | Power-control write strobe from the core |
| pcon_wdata | input | 2 | Bit 1 deep sleep, bit 0 light sleep |
| ie_en | input | 1 | Global interrupt enable from the core |
| ext_prog | input | 1 | Core fetches from external program memory |
| isr_ack | input | 1 | Core has entered the wake service routine |
| wake_clk_n | input | 1 | Wake pin, falling edge active |
| wake_data_n | input | 1 | Wake pin, falling edge active |
| wake_p2_n | input | 8 | Port 2 wake pins, falling edge active |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Core clock enable |
| wake_vec | output | 1 | Pulse: vector to wake routine, then return to next instruction |
| wake_resume | output | 1 | Pulse: resume at next instruction, no routine |
| idf | output | 1 | Idle/wake flag |
| ale_ovr_en | output | 1 | Override address-latch pin |
| ale_ovr_val | output | 1 | Forced address-latch level |
| psen_ovr_en | output | 1 | Override program-strobe pin |
| psen_ovr_val | output | 1 | Forced program-strobe level |
| p0_float | output | 1 | Tri-state port 0 |
| p2_hold_data | output | 1 | Port 2 shows latched data instead of address |

## Verification
Two events can meet on the same edge: hardware setting `idf` as the wake-action cycle begins, and the core clearing it with `isr_ack`. The bench computes the edge on which the wake action is due from R6. In a random share of the wake trials it raises `isr_ack` during the cycle just before that edge. It then expects `idf` to read 1 in the wake-action cycle and 0 only one edge later, after the acknowledge has acted on its own.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_STAB,
        ST_WAKE
    } pwr_state_e;

    localparam int PCON_IDL_BIT = 0;
    localparam int PCON_PD_BIT  = 1;
endpackage

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch #(
    parameter int NPIN = 10
) (
    input  logic            clk,
    input  logic            armed,
    input  logic [NPIN-1:0] pins_n,
    output logic            wk_raw,
    output logic            wk_sync
);
    logic all_high;
    logic [1:0] sync_q;

    assign all_high = &pins_n;

    // Set by the first falling pin while armed; cleared whenever disarmed.
    always_ff @(negedge all_high or negedge armed) begin
        if (!armed) wk_raw <= 1'b0;
        else        wk_raw <= 1'b1;
    end

    always_ff @(posedge clk or negedge armed) begin
        if (!armed) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], wk_raw};
    end

    assign wk_sync = sync_q[1];
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
    parameter int CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else if (!done) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pwr_pin_ovr.sv
module pwr_pin_ovr (
    input  logic idle_m,
    input  logic pd_m,
    input  logic ext_prog,
    output logic ale_en,
    output logic ale_val,
    output logic psen_en,
    output logic psen_val,
    output logic p0_float,
    output logic p2_hold
);
    always_comb begin
        ale_en   = idle_m | pd_m;
        psen_en  = idle_m | pd_m;
        ale_val  = idle_m & ~pd_m;
        psen_val = idle_m & ~pd_m;
        p0_float = ext_prog & (idle_m | pd_m);
        p2_hold  = ext_prog & pd_m;
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int STAB_CYC = 1024,
    parameter int P2_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pcon_we,
    input  logic [1:0]      pcon_wdata,
    input  logic            ie_en,
    input  logic            ext_prog,
    input  logic            isr_ack,
    input  logic            wake_clk_n,
    input  logic            wake_data_n,
    input  logic [P2_W-1:0] wake_p2_n,
    output logic            osc_en,
    output logic            cpu_clk_en,
    output logic            wake_vec,
    output logic            wake_resume,
    output logic            idf,
    output logic            ale_ovr_en,
    output logic            ale_ovr_val,
    output logic            psen_ovr_en,
    output logic            psen_ovr_val,
    output logic            p0_float,
    output logic            p2_hold_data
);
    localparam int NPIN = P2_W + 2;

    pwr_state_e state_q, state_d;
    logic armed_q, ie_q, wk_raw, wk_sync, stab_done, stab_run;
    logic idle_m, pd_m, take_write;

    pwr_wake_latch #(.NPIN(NPIN)) u_latch (
        .clk     (clk),
        .armed   (armed_q),
        .pins_n  ({wake_p2_n, wake_data_n, wake_clk_n}),
        .wk_raw  (wk_raw),
        .wk_sync (wk_sync)
    );

    assign stab_run = (state_q == ST_BOOT) || (state_q == ST_STAB);

    pwr_stab_timer #(.CYC(STAB_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (stab_run),
        .done  (stab_done)
    );

    assign take_write = pcon_we && (pcon_wdata != 2'b00) &&
                        ((state_q == ST_RUN) || (state_q == ST_WAKE));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  if (stab_done) state_d = ST_RUN;
            ST_RUN, ST_WAKE: begin
                if (pcon_we && pcon_wdata[PCON_PD_BIT])       state_d = ST_PDOWN;
                else if (pcon_we && pcon_wdata[PCON_IDL_BIT]) state_d = ST_IDLE;
                else                                          state_d = ST_RUN;
            end
            ST_IDLE:  if (wk_sync)   state_d = ST_WAKE;
            ST_PDOWN: if (wk_sync)   state_d = ST_STAB;
            ST_STAB:  if (stab_done) state_d = ST_WAKE;
            default:                 state_d = ST_BOOT;
        endcase
    end

    // State register with sleep bookkeeping that moves with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            armed_q <= 1'b0;
            ie_q    <= 1'b0;
            idf     <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= (state_d == ST_IDLE) || (state_d == ST_PDOWN);
            if (take_write) ie_q <= ie_en;
            if (state_d == ST_WAKE && state_q != ST_WAKE) idf <= 1'b1;
            else if (isr_ack)                             idf <= 1'b0;
        end
    end

    always_comb begin
        cpu_clk_en  = 1'b0;
        osc_en      = 1'b1;
        wake_vec    = 1'b0;
        wake_resume = 1'b0;
        idle_m      = 1'b0;
        pd_m        = 1'b0;
        unique case (state_q)
            ST_BOOT:  ;
            ST_RUN:   cpu_clk_en = 1'b1;
            ST_IDLE:  idle_m = 1'b1;
            ST_PDOWN: begin
                pd_m   = 1'b1;
                osc_en = wk_raw;
            end
            ST_STAB:  pd_m = 1'b1;
            ST_WAKE: begin
                cpu_clk_en  = 1'b1;
                wake_vec    = ie_q;
                wake_resume = ~ie_q;
            end
            default:  ;
        endcase
    end

    pwr_pin_ovr u_ovr (
        .idle_m   (idle_m),
        .pd_m     (pd_m),
        .ext_prog (ext_prog),
        .ale_en   (ale_ovr_en),
        .ale_val  (ale_ovr_val),
        .psen_en  (psen_ovr_en),
        .psen_val (psen_ovr_val),
        .p0_float (p0_float),
        .p2_hold  (p2_hold_data)
    );
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pcon_we,
    input logic [1:0] pcon_wdata,
    input logic       ext_prog,
    input logic       osc_en,
    input logic       cpu_clk_en,
    input logic       wake_vec,
    input logic       wake_resume,
    input logic       idf,
    input logic       ale_ovr_en,
    input logic       ale_ovr_val,
    input logic       p0_float,
    input logic       p2_hold_data
);
    assert_osc_gates_core_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);

    assert_pd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && pcon_we && pcon_wdata[1]) |=>
        (!cpu_clk_en && ale_ovr_en && !ale_ovr_val));

    assert_idle_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && pcon_we && pcon_wdata == 2'b01) |=>
        (!cpu_clk_en && osc_en && ale_ovr_en && ale_ovr_val));

    assert_single_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_vec && wake_resume));

    assert_action_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vec || wake_resume) |=> !(wake_vec || wake_resume));

    assert_flag_on_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vec || wake_resume) |-> idf);

    assert_p2_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        p2_hold_data |-> (p0_float && ext_prog));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pcon_we      (pcon_we),
    .pcon_wdata   (pcon_wdata),
    .ext_prog     (ext_prog),
    .osc_en       (osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .wake_vec     (wake_vec),
    .wake_resume  (wake_resume),
    .idf          (idf),
    .ale_ovr_en   (ale_ovr_en),
    .ale_ovr_val  (ale_ovr_val),
    .p0_float     (p0_float),
    .p2_hold_data (p2_hold_data)
);

// File: tb/pwr_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb_top;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pcon_we = 1'b0;
    logic [1:0] pcon_wdata = 2'b00;
    logic ie_en = 1'b0, ext_prog = 1'b0, isr_ack = 1'b0;
    logic [9:0] pins_n = '1;
    logic osc_en, cpu_clk_en, wake_vec, wake_resume, idf;
    logic ale_ovr_en, ale_ovr_val, psen_ovr_en, psen_ovr_val, p0_float, p2_hold_data;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 1'b0;
    bit exp_idf = 1'b0;

    // 250 MHz oscillator model that freezes low while disabled.
    always #2 clk = osc_en ? ~clk : 1'b0;

    pwr_wake_ctrl #(.STAB_CYC(N), .P2_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
        .ie_en(ie_en), .ext_prog(ext_prog), .isr_ack(isr_ack),
        .wake_clk_n(pins_n[0]), .wake_data_n(pins_n[1]), .wake_p2_n(pins_n[9:2]),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .wake_vec(wake_vec),
        .wake_resume(wake_resume), .idf(idf),
        .ale_ovr_en(ale_ovr_en), .ale_ovr_val(ale_ovr_val),
        .psen_ovr_en(psen_ovr_en), .psen_ovr_val(psen_ovr_val),
        .p0_float(p0_float), .p2_hold_data(p2_hold_data)
    );

    function automatic int exp_wake_edges(bit pd);
        return pd ? 3 + N : 3;
    endfunction

    function automatic bit exp_force_level(bit pd);
        return !pd;
    endfunction

    function automatic bit exp_p2_hold(bit pd, bit ext);
        return pd && ext;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle_after_reset(string req);
        for (int i = 1; i <= N; i++) begin
            step();
            if (i == N - 1) check({req, " clk gated near end of settle"}, cpu_clk_en, 0);
            if (i == N)     check({req, " clk enabled after settle"}, cpu_clk_en, 1);
        end
    endtask

    task automatic sleep_trial(bit [1:0] mode, bit ie, bit ext, int pin, bit collide);
        bit pd = mode[1];
        int edges = 0;
        int exp_e = exp_wake_edges(pd);
        ext_prog = ext; ie_en = ie; pcon_wdata = mode; pcon_we = 1'b1;
        step();
        pcon_we = 1'b0; pcon_wdata = 2'b00;
        ie_en = ~ie; // R8: change while asleep must not matter
        check(pd ? "R2/R4 core clk off" : "R3 core clk off", cpu_clk_en, 0);
        check(pd ? "R2 osc off" : "R3 osc on", osc_en, !pd);
        check("R2/R3 ale override", {ale_ovr_en, ale_ovr_val}, {1'b1, exp_force_level(pd)});
        check("R2/R3 psen override", {psen_ovr_en, psen_ovr_val}, {1'b1, exp_force_level(pd)});
        check("R10 p0 float", p0_float, ext);
        check("R10 p2 hold", p2_hold_data, exp_p2_hold(pd, ext));
        if (pd) begin
            #10;
            check("R2 osc stays off asleep", osc_en, 0);
        end
        pins_n[pin] = 1'b0;
        #0.5;
        if (pd) check("R5 osc restarts without clock", osc_en, 1);
        for (int i = 1; i <= exp_e + 4; i++) begin
            if (collide && i == exp_e) isr_ack = 1'b1;
            @(posedge clk);
            #1;
            edges = i;
            if (wake_vec || wake_resume) break;
            check("R6 core clk gated before wake", cpu_clk_en, 0);
        end
        pins_n[pin] = 1'b1;
        check("R5/R6 wake edge count", edges, exp_e);
        check("R6 core clk in wake cycle", cpu_clk_en, 1);
        check("R7/R8 action choice", {wake_vec, wake_resume}, {ie, !ie});
        exp_idf = 1'b1;
        check(collide ? "R9 set wins over ack" : "R9 flag set", idf, exp_idf);
        check("R10 overrides released", {ale_ovr_en, psen_ovr_en, p0_float}, 3'b000);
        step();
        check("R7 action one cycle", {wake_vec, wake_resume}, 2'b00);
        if (collide) begin
            exp_idf = 1'b0;
            isr_ack = 1'b0;
            check("R9 ack clears after collision", idf, exp_idf);
        end else if (ie) begin
            isr_ack = 1'b1;
            step();
            isr_ack = 1'b0;
            exp_idf = 1'b0;
            check("R9 ack clears flag", idf, exp_idf);
        end else begin
            step();
            check("R9 flag held without ack", idf, exp_idf);
        end
        // R12: pin activity while running
        pins_n[(pin + 3) % 10] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R12 no wake while running", {wake_vec, wake_resume, cpu_clk_en}, 3'b001);
        end
        check("R12 flag unchanged", idf, exp_idf);
        pins_n[(pin + 3) % 10] = 1'b1;
        step();
    endtask

    initial begin
        #700000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        int seed = 1234567;
        int r;
        r = $urandom(seed);
        #7;
        check("R1 osc on in reset", osc_en, 1);
        check("R1 core clk off in reset", cpu_clk_en, 0);
        check("R1 flag clear", idf, 0);
        check("R1 no overrides", {ale_ovr_en, psen_ovr_en, p0_float, p2_hold_data}, 4'b0000);
        @(posedge clk); #1;
        rst_n = 1'b1;
        settle_after_reset("R1");

        // Directed corners
        sleep_trial(2'b10, 1'b1, 1'b1, 0, 1'b0);
        sleep_trial(2'b01, 1'b0, 1'b1, 9, 1'b0);
        sleep_trial(2'b11, 1'b0, 1'b0, 1, 1'b1);
        sleep_trial(2'b01, 1'b1, 1'b0, 5, 1'b1);

        for (int it = 0; it < 40; it++) begin
            bit [1:0] m;
            r = $urandom() % 3;
            m = (r == 0) ? 2'b01 : ((r == 1) ? 2'b10 : 2'b11);
            sleep_trial(m, 1'($urandom()), 1'($urandom()),
                        int'($urandom() % 10), ($urandom() % 4) == 0);
        end

        // R11: reset during deep sleep
        pcon_wdata = 2'b10; pcon_we = 1'b1;
        step();
        pcon_we = 1'b0; pcon_wdata = 2'b00;
        #10;
        check("R11 asleep before reset", osc_en, 0);
        rst_n = 1'b0;
        #0.5;
        check("R11 osc on at reset", osc_en, 1);
        check("R11 flag cleared", idf, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        settle_after_reset("R11");
        exp_idf = 1'b0;
        sleep_trial(2'b10, 1'b0, 1'b1, 7, 1'b0);
        summary();
    end
endmodule